// File: doc/BRIEF.md
# Multi-Level Indirect Address Resolver

This block turns a starting pointer into a final effective address by walking a chain of memory-indirect words. It reads the word at the current pointer and computes a candidate address. That address is the word's address field, plus the contents of an index register when the word selects one. If the word's indirect flag is set, the candidate becomes the next pointer and another read follows. If the flag is clear, the candidate is the result. Every level of the chain costs exactly one memory read.

The resolver talks to memory through a read port that allows only one request at a time. It looks up index registers through a combinational lookup port, because the register file is outside the block. A configurable limit on the number of reads keeps it from hanging on a chain that points back to itself. When the limit is hit, the block reports an error instead of a result.

Top module: `indirect_resolver`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done`, `error`, `memReq` and `busy` are all low.
- R2: A fetched word is decoded as follows. The address is bits [ADDR_W-1:0] (17:0 by default). The index selector is the next SEL_W bits (21:18). The indirect flag is the bit above the selector (bit 22). Any bits above the flag (35:23) have no effect on the result.
- R3: A start accepted in idle makes the first read at `startAddr`. Each read raises `memReq` for exactly one cycle, with `memAddr` valid in that cycle. No further request is raised until `memValid` has returned that word.
- R4: When a fetched word's indirect flag is 1, the next read uses the candidate address computed from that word. When the flag is 0, the candidate address is the final result.
- R5: The candidate address is the address field plus the value on `idxVal` for the selector driven on `idxSel`, taken modulo 2^ADDR_W. Selector value 0 adds nothing, whatever `idxVal` carries.
- R6: A walk that would need more than MAX_DEPTH reads (default 16) stops after MAX_DEPTH reads. It then raises `error` for one cycle and does not raise `done`. A word that points to itself ends this way.
- R7: `done` is high for exactly one cycle, and `effAddr` holds the result in that cycle. In the cycle after `done` or `error`, `busy` is low.
- R8: A `start` pulse that arrives while `busy` is high is ignored. The walk in progress completes with its own result, and no extra result is produced.
- R9: Let N be the number of reads and L the memory latency in cycles from the request edge to the cycle `memValid` is high. Then `done` or `error` appears N*(L+2) clock edges after the edge that accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a walk (accepted only when idle) |
| startAddr | input | ADDR_W | Address of the first pointer word |
| busy | output | 1 | High from acceptance until the cycle after the result |
| memReq | output | 1 | One-cycle read request |
| memAddr | output | ADDR_W | Read address |
| memValid | input | 1 | Read data valid |
| memRdata | input | WORD_W | Read data word |
| idxSel | output | SEL_W | Index selector of the word under evaluation |
| idxVal | input | ADDR_W | Contents of the selected index register |
| done | output | 1 | Result pulse |
| effAddr | output | ADDR_W | Final effective address |
| error | output | 1 | Depth-limit pulse |

## Verification
Each result is due N*(L+2) edges after the accepting edge. N is the number of reads the chain needs and L is the latency of the memory model. The driver works out N and the result from its own walk over the bench memory image, and records the due cycle together with the expected address. The monitor samples on falling edges, pops the record when `done` or `error` appears, and compares the cycle as well as the value. One falling edge later it confirms `busy` is low, so a stretched pulse or a stray extra result is caught as a miscompare.

// File: rtl/indres_pkg.sv
package indres_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_EVAL,
    ST_DONE,
    ST_ERROR
  } resState_t;

  typedef struct packed {
    logic loadStart;
    logic captureWord;
    logic loadNext;
    logic loadResult;
  } dpCtrl_t;

endpackage

// File: rtl/indres_datapath.sv
module indres_datapath
  import indres_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int WORD_W = 36,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [WORD_W-1:0] memRdata,
  input  logic [ADDR_W-1:0] idxVal,
  output logic [ADDR_W-1:0] memAddr,
  output logic [SEL_W-1:0]  idxSel,
  output logic              indFlag,
  output logic [ADDR_W-1:0] effAddr
);

  localparam int SEL_LO   = ADDR_W;
  localparam int FLAG_BIT = ADDR_W + SEL_W;

  logic [ADDR_W-1:0] ptrQ;
  logic [ADDR_W-1:0] effQ;
  logic [WORD_W-1:0] wordQ;
  logic [ADDR_W-1:0] wordAddr;
  logic [ADDR_W-1:0] addend;
  logic [ADDR_W-1:0] candAddr;

  assign wordAddr = wordQ[ADDR_W-1:0];
  assign idxSel   = wordQ[SEL_LO +: SEL_W];
  assign indFlag  = wordQ[FLAG_BIT];
  assign addend   = (idxSel != '0) ? idxVal : '0;
  assign candAddr = wordAddr + addend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ  <= '0;
      wordQ <= '0;
      effQ  <= '0;
    end else begin
      if (ctrl.loadStart)   ptrQ  <= startAddr;
      else if (ctrl.loadNext) ptrQ <= candAddr;
      if (ctrl.captureWord) wordQ <= memRdata;
      if (ctrl.loadResult)  effQ  <= candAddr;
    end
  end

  assign memAddr = ptrQ;
  assign effAddr = effQ;

  // a selector of zero must leave the address field untouched
  assert_sel_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadResult && idxSel == '0) |=> effAddr == $past(memRdata_addr_q()))
    else $error("R5 selector zero added an index");

  function automatic logic [ADDR_W-1:0] memRdata_addr_q();
    return wordQ[ADDR_W-1:0];
  endfunction

endmodule

// File: rtl/indres_control.sv
module indres_control
  import indres_pkg::*;
#(
  parameter int MAX_DEPTH = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    memValid,
  input  logic    indFlag,
  output dpCtrl_t ctrl,
  output logic    memReq,
  output logic    busy,
  output logic    done,
  output logic    error
);

  localparam int DEPTH_W = $clog2(MAX_DEPTH + 1);
  localparam logic [DEPTH_W-1:0] DEPTH_LIMIT = DEPTH_W'(MAX_DEPTH);

  resState_t stateQ, stateD;
  logic [DEPTH_W-1:0] depthQ, depthD;

  always_comb begin
    stateD = stateQ;
    depthD = depthQ;
    ctrl   = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          ctrl.loadStart = 1'b1;
          depthD = '0;
          stateD = ST_FETCH;
        end
      end
      ST_FETCH: begin
        depthD = depthQ + 1'b1;
        stateD = ST_WAIT;
      end
      ST_WAIT: begin
        if (memValid) begin
          ctrl.captureWord = 1'b1;
          stateD = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (indFlag) begin
          if (depthQ == DEPTH_LIMIT) begin
            stateD = ST_ERROR;
          end else begin
            ctrl.loadNext = 1'b1;
            stateD = ST_FETCH;
          end
        end else begin
          ctrl.loadResult = 1'b1;
          stateD = ST_DONE;
        end
      end
      ST_DONE:  stateD = ST_IDLE;
      ST_ERROR: stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      depthQ <= '0;
    end else begin
      stateQ <= stateD;
      depthQ <= depthD;
    end
  end

  assign memReq = (stateQ == ST_FETCH);
  assign busy   = (stateQ != ST_IDLE);
  assign done   = (stateQ == ST_DONE);
  assign error  = (stateQ == ST_ERROR);

  assert_single_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq)
    else $error("R3 request held longer than one cycle");

  assert_no_req_before_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAIT && !memValid) |=> !memReq)
    else $error("R3 new request before data returned");

  assert_depth_cap_R6: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> depthQ < DEPTH_LIMIT)
    else $error("R6 read issued beyond depth limit");

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy))
    else $error("R7 done not a single-cycle pulse");

  assert_error_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    error |=> (!error && !busy))
    else $error("R6 error not a single-cycle pulse");

  assert_outputs_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, error, memReq}))
    else $error("R7 done, error and request overlap");

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && !error) |=> busy)
    else $error("R8 walk abandoned while busy");

endmodule

// File: rtl/indirect_resolver.sv
module indirect_resolver
  import indres_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int WORD_W    = 36,
  parameter int SEL_W     = 4,
  parameter int MAX_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  output logic              busy,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [WORD_W-1:0] memRdata,
  output logic [SEL_W-1:0]  idxSel,
  input  logic [ADDR_W-1:0] idxVal,
  output logic              done,
  output logic [ADDR_W-1:0] effAddr,
  output logic              error
);

  dpCtrl_t ctrl;
  logic    indFlag;

  indres_control #(.MAX_DEPTH(MAX_DEPTH)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .memValid (memValid),
    .indFlag  (indFlag),
    .ctrl     (ctrl),
    .memReq   (memReq),
    .busy     (busy),
    .done     (done),
    .error    (error)
  );

  indres_datapath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .SEL_W(SEL_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .startAddr (startAddr),
    .memRdata  (memRdata),
    .idxVal    (idxVal),
    .memAddr   (memAddr),
    .idxSel    (idxSel),
    .indFlag   (indFlag),
    .effAddr   (effAddr)
  );

endmodule

// File: tb/indirect_resolver_test.sv
module indirect_resolver_test;

  localparam int ADDR_W = 18;
  localparam int WORD_W = 36;
  localparam int SEL_W  = 4;
  localparam int MAXD   = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic              busy, memReq, done, error;
  logic [ADDR_W-1:0] memAddr, effAddr, idxVal;
  logic              memValid = 1'b0;
  logic [WORD_W-1:0] memRdata = '0;
  logic [SEL_W-1:0]  idxSel;

  always #10 clk = ~clk; // 50 MHz

  indirect_resolver uut (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .busy(busy), .memReq(memReq), .memAddr(memAddr),
    .memValid(memValid), .memRdata(memRdata),
    .idxSel(idxSel), .idxVal(idxVal),
    .done(done), .effAddr(effAddr), .error(error)
  );

  logic [WORD_W-1:0] memImg [int];
  logic [ADDR_W-1:0] regFile [16];
  assign idxVal = regFile[idxSel];

  int memLat = 1;
  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;
  bit chkIdle = 0;

  typedef struct {
    bit              isErr;
    logic [ADDR_W-1:0] addr;
    int              dueCyc;
    string           tag;
  } expItem_t;
  expItem_t expQ[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [WORD_W-1:0] mkWord(bit ind, int sel, int addr);
    logic [WORD_W-1:0] w;
    w = '0;
    w[ADDR_W-1:0] = ADDR_W'(addr);
    w[ADDR_W +: SEL_W] = SEL_W'(sel);
    w[ADDR_W+SEL_W] = ind;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] readMem(logic [ADDR_W-1:0] a);
    if (memImg.exists(int'(a))) return memImg[int'(a)];
    return '0;
  endfunction

  // memory model: one request at a time, data memLat cycles after the request edge
  initial begin
    logic [ADDR_W-1:0] reqAddr;
    forever begin
      @(posedge clk);
      if (memReq === 1'b1) begin
        reqAddr = memAddr;
        repeat (memLat - 1) @(posedge clk);
        memValid <= 1'b1;
        memRdata <= readMem(reqAddr);
        @(posedge clk);
        memValid <= 1'b0;
        memRdata <= '0;
      end
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  // independent walk of the chain from the requirements
  task automatic runExpect(int a, string tag);
    expItem_t it;
    logic [ADDR_W-1:0] p, cand;
    logic [WORD_W-1:0] w;
    int reads;
    p = ADDR_W'(a);
    reads = 0;
    it.isErr = 0;
    it.addr = '0;
    it.tag = tag;
    forever begin
      w = readMem(p);
      reads++;
      cand = w[ADDR_W-1:0] +
             ((w[ADDR_W +: SEL_W] != 0) ? regFile[w[ADDR_W +: SEL_W]] : '0);
      if (w[ADDR_W+SEL_W]) begin
        if (reads == MAXD) begin it.isErr = 1; break; end
        p = cand;
      end else begin
        it.addr = cand;
        break;
      end
    end
    @(negedge clk);
    it.dueCyc = cyc + 1 + reads * (memLat + 2);
    expQ.push_back(it);
    start = 1'b1;
    startAddr = ADDR_W'(a);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDrain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (chkIdle) begin
        check(!busy && !done && !error, "R7", "idle after result", busy, 0);
        chkIdle = 0;
      end
      if (done || error) begin
        chkIdle = 1;
        if (expQ.size() == 0) begin
          check(0, "R8", "unexpected result", {done, error}, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(error == e.isErr && done == !e.isErr, e.tag, "result kind",
                {done, error}, e.isErr ? 1 : 2);
          if (!e.isErr) check(effAddr == e.addr, e.tag, "effAddr", effAddr, e.addr);
          check(cyc == e.dueCyc, "R9", "result cycle", cyc, e.dueCyc);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    finish();
  end

  initial begin
    for (int i = 0; i < 16; i++) regFile[i] = ADDR_W'(32'h111 * (i + 1));
    regFile[3]  = 18'h00040;
    regFile[5]  = 18'h00020;
    // R2: direct word with junk in the unused upper bits
    memImg[10] = mkWord(0, 0, 'h1234) | {13'h1FFF, 23'h0};
    // R4/R5: two levels, index 3 added at level one
    memImg[20] = mkWord(1, 3, 'h100);
    memImg['h140] = mkWord(0, 0, 'h2BEEF);
    // R5: selector 0 with a nonzero register 0
    memImg[30] = mkWord(1, 0, 'h200);
    memImg['h200] = mkWord(0, 0, 'h3333);
    // R5: wrap-around
    memImg[40] = mkWord(0, 5, 'h3FFF0);
    // R6: chain of exactly MAXD reads (100..115), one longer from 99
    for (int i = 0; i < MAXD - 1; i++) memImg[100 + i] = mkWord(1, 0, 101 + i);
    memImg[100 + MAXD - 1] = mkWord(0, 0, 'h2AAAA);
    memImg[99] = mkWord(1, 0, 100);
    // R6: self-reference
    memImg[50] = mkWord(1, 0, 50);
    // R8: target for an ignored start
    memImg[60] = mkWord(0, 0, 'h0BAD);

    repeat (2) @(negedge clk);
    check(!done && !error && !memReq && !busy, "R1", "outputs in reset",
          {done, error, memReq, busy}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!done && !error && !memReq && !busy, "R1", "outputs after reset",
          {done, error, memReq, busy}, 0);

    runExpect(10, "R2"); waitDrain();
    runExpect(20, "R4"); waitDrain();
    runExpect(30, "R5"); waitDrain();
    runExpect(40, "R5"); waitDrain();
    runExpect(100, "R6"); waitDrain();
    runExpect(99, "R6"); waitDrain();
    runExpect(50, "R6"); waitDrain();

    // R3: first request at the start address
    fork
      runExpect(20, "R3");
      begin
        @(posedge memReq);
        @(negedge clk);
        check(memAddr == 20, "R3", "first read address", memAddr, 20);
      end
    join
    waitDrain();

    // R8: start pulse in the middle of a walk
    fork
      runExpect(20, "R8");
      begin
        repeat (3) @(negedge clk);
        start = 1'b1; startAddr = 60;
        @(negedge clk);
        start = 1'b0;
      end
    join
    waitDrain();

    // R9: slower memory
    memLat = 3;
    runExpect(20, "R9"); waitDrain();
    runExpect(100, "R9"); waitDrain();
    memLat = 1;
    runExpect(10, "R2"); waitDrain();

    check(expQ.size() == 0, "R7", "all results seen", expQ.size(), 0);
    finish();
  end

endmodule